// File: doc/BRIEF.md
# Reserved-Opcode Extension Hook

This unit sits next to the decode stage of a base processor. It lets a stacked extension layer add new instructions without any change to the base core's datapath. The base control unit knows a fixed list of opcodes. Every other opcode, including a reserved block at the top of the opcode space, retires in the base core as a no-operation. The unit flags those no-operations to the pipeline.

When a reserved opcode reaches decode and the extension layer reports itself present, the unit does four things:

- It stalls the pipeline.
- It captures the opcode and the three register addresses.
- It passes on only the register values that the opcode marks as shared with the layer.
- It presents all of this as one request, using a valid/ready handshake.

When the layer answers, the unit takes over the register-file writeback for that cycle and writes the layer's result. An error answer blocks the write and raises a one-cycle illegal-instruction pulse. With no layer attached, reserved opcodes go through as plain no-operations and the pipeline does not stall.

Top module: `ext_hook_top`

## Requirements
- R1: While reset is held, stall, extReqValid and illegalPulse are low, and writeback outputs follow the base writeback inputs.
- R2: decNop is high exactly when decValid is high and decOpcode >= NUM_DEF (default 40). The base core defines only opcodes 0..NUM_DEF-1, so undefined and reserved opcodes are both no-operations.
- R3: A reserved opcode (decOpcode >= 6'h38) on a valid decode with extPresent high, while the unit is idle, raises stall in that same cycle. extReqValid rises in the next cycle and stays high until the cycle in which extReqReady is seen high.
- R4: While extReqValid is high, extReqOpcode, extReqRd, extReqRs1 and extReqRs2 carry the values decoded in the issue cycle and do not change.
- R5: extReqOpA carries rs1Val captured at issue if opcode bit 0 is 1, and zero otherwise. extReqOpB carries rs2Val if opcode bit 1 is 1, and zero otherwise.
- R6: After the request is accepted, stall stays high until the cycle in which extRspValid is high. In that cycle stall is low.
- R7: A response without error forces wbEn=1, wbAddr to the captured rd, and wbData to extRspData, all in the response cycle.
- R8: A response with extRspErr=1 forces wbEn=0 and drives illegalPulse high for that cycle only.
- R9: With extPresent low, reserved opcodes cause no stall and no request, and the writeback outputs follow the base inputs.
- R10: In any cycle without a response override, wbEn, wbAddr and wbData equal baseWbEn, baseWbAddr and baseWbData.
- R11: extRspValid is ignored unless a request has been accepted and is waiting. It then causes no override and no illegalPulse.
- R12: Only one request is outstanding at a time. Each reserved opcode, even back to back, gets exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPresent | input | 1 | Extension layer attached |
| decValid | input | 1 | Decode slot holds an instruction |
| decOpcode | input | 6 | Decoded opcode |
| decRd | input | 5 | Destination register address |
| decRs1 | input | 5 | First source address |
| decRs2 | input | 5 | Second source address |
| rs1Val | input | 32 | First source value |
| rs2Val | input | 32 | Second source value |
| baseWbEn | input | 1 | Base writeback enable |
| baseWbAddr | input | 5 | Base writeback address |
| baseWbData | input | 32 | Base writeback data |
| extReqReady | input | 1 | Layer accepts request |
| extRspValid | input | 1 | Layer response valid |
| extRspErr | input | 1 | Layer response error |
| extRspData | input | 32 | Layer result |
| decNop | output | 1 | Decoded instruction retires as no-op in base |
| stall | output | 1 | Hold the pipeline |
| extReqValid | output | 1 | Request valid |
| extReqOpcode | output | 6 | Captured opcode |
| extReqRd | output | 5 | Captured destination |
| extReqRs1 | output | 5 | Captured source 1 address |
| extReqRs2 | output | 5 | Captured source 2 address |
| extReqOpA | output | 32 | Shared source 1 value or zero |
| extReqOpB | output | 32 | Shared source 2 value or zero |
| wbEn | output | 1 | Register-file write enable |
| wbAddr | output | 5 | Register-file write address |
| wbData | output | 32 | Register-file write data |
| illegalPulse | output | 1 | Error response strobe |

## Verification
The assertions rely on three things about the environment:

- The pipeline holds the decode slot steady while stall is high.
- extPresent changes only while the unit is idle.
- The layer does not drop a response on the floor.

The stimulus meets all three. It keeps each reserved instruction on the decode inputs until the response cycle and then clears decode. It changes extPresent only between transactions. It gives exactly one response per accepted request, apart from one deliberate response sent while idle. The base writeback inputs are randomized on every cycle, so every passthrough cycle is compared against fresh values.

// File: rtl/ext_hook_pkg.sv
package ext_hook_pkg;
  typedef enum logic [1:0] {
    HK_IDLE = 2'd0,
    HK_REQ  = 2'd1,
    HK_WAIT = 2'd2
  } hookState_t;

  typedef struct packed {
    logic capture;   // latch decode fields into the request registers
    logic override;  // take over writeback this cycle
    logic wbKeep;    // override writes (1) or blocks (0)
  } hookStrobe_t;
endpackage

// File: rtl/ext_hook_ctrl.sv
module ext_hook_ctrl
  import ext_hook_pkg::*;
#(
  parameter int OPC_W  = 6,
  parameter int RSV_LO = 56
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extPresent,
  input  logic             decValid,
  input  logic [OPC_W-1:0] decOpcode,
  input  logic             extReqReady,
  input  logic             extRspValid,
  input  logic             extRspErr,
  output logic             stall,
  output logic             reqValid,
  output logic             illegalPulse,
  output hookStrobe_t      strobe
);
  localparam logic [OPC_W-1:0] RsvLoCode = OPC_W'(RSV_LO);

  hookState_t state, stateNext;
  logic isRsv, issue, done;

  assign isRsv = decOpcode >= RsvLoCode;
  assign issue = (state == HK_IDLE) && decValid && isRsv && extPresent;
  assign done  = (state == HK_WAIT) && extRspValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      HK_IDLE: if (issue) stateNext = HK_REQ;
      HK_REQ:  if (extReqReady) stateNext = HK_WAIT;
      HK_WAIT: if (extRspValid) stateNext = HK_IDLE;
      default: stateNext = HK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= HK_IDLE;
    else       state <= stateNext;
  end

  assign reqValid       = (state == HK_REQ);
  assign stall          = issue || (state == HK_REQ) || ((state == HK_WAIT) && !extRspValid);
  assign illegalPulse   = done && extRspErr;
  assign strobe.capture  = issue;
  assign strobe.override = done;
  assign strobe.wbKeep   = !extRspErr;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !extReqReady |=> reqValid) else $error("request dropped"); // R3
  AST_REQ_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> stall) else $error("request without stall"); // R6
  AST_ILLEGAL_ONE: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |=> !illegalPulse) else $error("illegal pulse too long"); // R8
  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !extPresent && (state == HK_IDLE) |-> !stall) else $error("stall without layer"); // R9
  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == HK_WAIT) |=> !reqValid) else $error("second request while waiting"); // R12
endmodule

// File: rtl/ext_hook_dp.sv
module ext_hook_dp
  import ext_hook_pkg::*;
#(
  parameter int OPC_W   = 6,
  parameter int REG_AW  = 5,
  parameter int XLEN    = 32,
  parameter int NUM_DEF = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  hookStrobe_t       strobe,
  input  logic              reqValid,
  input  logic              illegalPulse,
  input  logic              decValid,
  input  logic [OPC_W-1:0]  decOpcode,
  input  logic [REG_AW-1:0] decRd,
  input  logic [REG_AW-1:0] decRs1,
  input  logic [REG_AW-1:0] decRs2,
  input  logic [XLEN-1:0]   rs1Val,
  input  logic [XLEN-1:0]   rs2Val,
  input  logic              baseWbEn,
  input  logic [REG_AW-1:0] baseWbAddr,
  input  logic [XLEN-1:0]   baseWbData,
  input  logic              extReqReady,
  input  logic [XLEN-1:0]   extRspData,
  output logic              decNop,
  output logic [OPC_W-1:0]  reqOpcode,
  output logic [REG_AW-1:0] reqRd,
  output logic [REG_AW-1:0] reqRs1,
  output logic [REG_AW-1:0] reqRs2,
  output logic [XLEN-1:0]   reqOpA,
  output logic [XLEN-1:0]   reqOpB,
  output logic              wbEn,
  output logic [REG_AW-1:0] wbAddr,
  output logic [XLEN-1:0]   wbData
);
  localparam int NUM_SRC = 2;
  localparam logic [OPC_W-1:0] DefLimit = OPC_W'(NUM_DEF);

  logic [NUM_SRC-1:0][XLEN-1:0] srcIn, srcQ;

  assign decNop   = decValid && (decOpcode >= DefLimit);
  assign srcIn[0] = rs1Val;
  assign srcIn[1] = rs2Val;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqOpcode <= '0;
      reqRd     <= '0;
      reqRs1    <= '0;
      reqRs2    <= '0;
    end else if (strobe.capture) begin
      reqOpcode <= decOpcode;
      reqRd     <= decRd;
      reqRs1    <= decRs1;
      reqRs2    <= decRs2;
    end
  end

  // opcode bit i marks source i as shared with the extension layer
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN)               srcQ[i] <= '0;
      else if (strobe.capture) srcQ[i] <= decOpcode[i] ? srcIn[i] : '0;
    end
  end

  assign reqOpA = srcQ[0];
  assign reqOpB = srcQ[1];

  assign wbEn   = strobe.override ? strobe.wbKeep : baseWbEn;
  assign wbAddr = strobe.override ? reqRd         : baseWbAddr;
  assign wbData = strobe.override ? extRspData    : baseWbData;

  AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !extReqReady |=> $stable(reqOpcode) && $stable(reqRd) && $stable(reqOpA)) else $error("payload moved"); // R4
  AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |-> !wbEn) else $error("write on error"); // R8
endmodule

// File: rtl/ext_hook_top.sv
module ext_hook_top
  import ext_hook_pkg::*;
#(
  parameter int OPC_W   = 6,
  parameter int REG_AW  = 5,
  parameter int XLEN    = 32,
  parameter int NUM_DEF = 40,
  parameter int RSV_LO  = 56
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extPresent,
  input  logic              decValid,
  input  logic [OPC_W-1:0]  decOpcode,
  input  logic [REG_AW-1:0] decRd,
  input  logic [REG_AW-1:0] decRs1,
  input  logic [REG_AW-1:0] decRs2,
  input  logic [XLEN-1:0]   rs1Val,
  input  logic [XLEN-1:0]   rs2Val,
  input  logic              baseWbEn,
  input  logic [REG_AW-1:0] baseWbAddr,
  input  logic [XLEN-1:0]   baseWbData,
  input  logic              extReqReady,
  input  logic              extRspValid,
  input  logic              extRspErr,
  input  logic [XLEN-1:0]   extRspData,
  output logic              decNop,
  output logic              stall,
  output logic              extReqValid,
  output logic [OPC_W-1:0]  extReqOpcode,
  output logic [REG_AW-1:0] extReqRd,
  output logic [REG_AW-1:0] extReqRs1,
  output logic [REG_AW-1:0] extReqRs2,
  output logic [XLEN-1:0]   extReqOpA,
  output logic [XLEN-1:0]   extReqOpB,
  output logic              wbEn,
  output logic [REG_AW-1:0] wbAddr,
  output logic [XLEN-1:0]   wbData,
  output logic              illegalPulse
);
  hookStrobe_t strobe;

  ext_hook_ctrl #(.OPC_W(OPC_W), .RSV_LO(RSV_LO)) u_ctrl (
    .clk(clk), .rstN(rstN), .extPresent(extPresent), .decValid(decValid),
    .decOpcode(decOpcode), .extReqReady(extReqReady), .extRspValid(extRspValid),
    .extRspErr(extRspErr), .stall(stall), .reqValid(extReqValid),
    .illegalPulse(illegalPulse), .strobe(strobe)
  );

  ext_hook_dp #(.OPC_W(OPC_W), .REG_AW(REG_AW), .XLEN(XLEN), .NUM_DEF(NUM_DEF)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqValid(extReqValid),
    .illegalPulse(illegalPulse), .decValid(decValid), .decOpcode(decOpcode),
    .decRd(decRd), .decRs1(decRs1), .decRs2(decRs2), .rs1Val(rs1Val), .rs2Val(rs2Val),
    .baseWbEn(baseWbEn), .baseWbAddr(baseWbAddr), .baseWbData(baseWbData),
    .extReqReady(extReqReady), .extRspData(extRspData), .decNop(decNop),
    .reqOpcode(extReqOpcode), .reqRd(extReqRd), .reqRs1(extReqRs1), .reqRs2(extReqRs2),
    .reqOpA(extReqOpA), .reqOpB(extReqOpB), .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData)
  );
endmodule

// File: tb/tb_ext_hook_top.sv
module tb_ext_hook_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extPresent = 1'b1;
  logic decValid = 1'b0;
  logic [5:0] decOpcode = '0;
  logic [4:0] decRd = '0, decRs1 = '0, decRs2 = '0;
  logic [31:0] rs1Val = '0, rs2Val = '0;
  logic baseWbEn = 1'b0;
  logic [4:0] baseWbAddr = '0;
  logic [31:0] baseWbData = '0;
  logic extReqReady = 1'b0, extRspValid = 1'b0, extRspErr = 1'b0;
  logic [31:0] extRspData = '0;
  logic decNop, stall, extReqValid, wbEn, illegalPulse;
  logic [5:0] extReqOpcode;
  logic [4:0] extReqRd, extReqRs1, extReqRs2, wbAddr;
  logic [31:0] extReqOpA, extReqOpB, wbData;

  int nChecks = 0;
  int nFails = 0;

  // reference model state: 0 idle, 1 request pending, 2 waiting for response
  int mSt = 0;
  logic [5:0] mOpc;
  logic [4:0] mRd, mRs1, mRs2;
  logic [31:0] mA, mB;

  ext_hook_top dut (.*);

  initial forever #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // randomized base writeback every cycle
  initial forever begin
    @(posedge clk); #1;
    baseWbEn   = 1'($urandom);
    baseWbAddr = 5'($urandom);
    baseWbData = $urandom;
  end

  // reference model advance
  always @(posedge clk) begin
    if (!rstN) mSt = 0;
    else case (mSt)
      0: if (decValid && decOpcode >= 6'h38 && extPresent) begin
           mSt = 1; mOpc = decOpcode; mRd = decRd; mRs1 = decRs1; mRs2 = decRs2;
           mA = decOpcode[0] ? rs1Val : 32'h0;
           mB = decOpcode[1] ? rs2Val : 32'h0;
         end
      1: if (extReqReady) mSt = 2;
      default: if (extRspValid) mSt = 0;
    endcase
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      chk("R1 stall", stall, 0);
      chk("R1 extReqValid", extReqValid, 0);
      chk("R1 illegalPulse", illegalPulse, 0);
    end else begin
      logic ovr, iss;
      iss = (mSt == 0) && decValid && decOpcode >= 6'h38 && extPresent;
      ovr = (mSt == 2) && extRspValid;
      chk("R2 decNop", decNop, decValid && decOpcode >= 6'd40);
      chk("R3 R6 R9 stall", stall, iss || mSt == 1 || (mSt == 2 && !extRspValid));
      chk("R3 R12 extReqValid", extReqValid, mSt == 1);
      if (mSt == 1) begin
        chk("R4 opcode", extReqOpcode, mOpc);
        chk("R4 addrs", {extReqRd, extReqRs1, extReqRs2}, {mRd, mRs1, mRs2});
        chk("R5 opA", extReqOpA, mA);
        chk("R5 opB", extReqOpB, mB);
      end
      chk("R8 R11 illegalPulse", illegalPulse, ovr && extRspErr);
      if (ovr) begin
        chk("R7 R8 wbEn", wbEn, !extRspErr);
        if (!extRspErr) chk("R7 wbAddr/wbData", {wbAddr, wbData}, {mRd, extRspData});
      end else begin
        chk("R10 wbEn", wbEn, baseWbEn);
        chk("R10 wbAddr/wbData", {wbAddr, wbData}, {baseWbAddr, baseWbData});
      end
    end
  end

  task automatic extOp(input logic [5:0] opc, input int readyDly, input int rspDly,
                       input logic err, input logic [31:0] res);
    decValid = 1; decOpcode = opc; decRd = 5'($urandom); decRs1 = 5'($urandom);
    decRs2 = 5'($urandom); rs1Val = $urandom; rs2Val = $urandom;
    @(posedge clk); #1;
    repeat (readyDly) begin @(posedge clk); #1; end
    extReqReady = 1;
    @(posedge clk); #1;
    extReqReady = 0;
    repeat (rspDly) begin @(posedge clk); #1; end
    extRspValid = 1; extRspErr = err; extRspData = res;
    @(posedge clk); #1;
    extRspValid = 0; extRspErr = 0; decValid = 0;
  endtask

  task automatic plainOp(input logic [5:0] opc, input int cycles);
    decValid = 1; decOpcode = opc;
    repeat (cycles) begin @(posedge clk); #1; end
    decValid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;
    plainOp(6'h05, 3);          // R10 defined opcode, passthrough
    plainOp(6'h30, 2);          // R2 undefined opcode is a no-op
    extOp(6'h38, 0, 0, 0, 32'hA5A5_0001);   // R7 fast path, no operands shared
    extOp(6'h3B, 3, 4, 0, 32'h1234_5678);   // R5 both shared, R6 long wait
    extOp(6'h3A, 1, 2, 1, 32'hDEAD_BEEF);   // R8 error response
    extRspValid = 1; extRspErr = 1; extRspData = 32'hFFFF_FFFF; // R11 stray response
    @(posedge clk); #1;
    extRspValid = 0; extRspErr = 0;
    extOp(6'h39, 0, 1, 0, 32'h0000_00C3);   // R12 back to back
    extOp(6'h3F, 2, 0, 0, 32'h0BAD_F00D);   // R12
    extPresent = 0;
    plainOp(6'h3F, 4);          // R9 absent layer
    extPresent = 1;
    repeat (3) @(posedge clk);
    #1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule